// File: doc/BRIEF.md
# Panel controller register and interrupt unit

This block is the software-visible control and status front end of a simple display panel controller. It sits on a 32-bit word register bus with six registers at byte offsets 0x00 to 0x14. It holds the control word, three timing words and a subpanel word. It decodes the panel width and height from the timing words and drives them out to the rest of the controller. It also drives the panel enable.

A separate fetch sequencer reports three events through single-cycle pulses: a frame finished, the palette was loaded, and a synchronisation fault. The block keeps these as sticky status flags and combines them into one level-sensitive interrupt line. Turning the panel on or off through the control word also updates the flags, the same way a real controller does at the edges of a display session.

Reads are combinational. Every readback merges the stored fields with fixed constant-ones patterns, so software sees the same values a hardware implementation with tied-high reserved bits would return.

Top module: `panel_ctl_regs`

## Requirements
- R1: Control (0x00) stores on-bit in bit 0, mono in bit 1, interrupt mask in bits 4:3, tft in bit 7, palette mode in bits 21:20, and other bits kept under mask 0x01CFF300. A read returns the OR of all of these with tft repeated in bit 23 and the constant 0xFE000C34.
- R2: Writing 0x04 sets panel_width to bits 9:0 plus one and keeps bits 31:10. A read returns bits 31:10, then (panel_width-1) in bits 9:0, ORed with 0x0000000F.
- R3: 0x08 handles panel_height the same way with no forced bits. 0x0C stores all 32 bits and reads back with bits 31:26 forced to one.
- R4: Status (0x10) reads frame-done in bit 0, sync-fault in bit 2 and palette-done in bit 6, with all other bits zero. Writes to 0x10 change nothing.
- R5: Subpanel (0x14) stores the written word ANDed with 0xA1FFFFFF and reads it back unchanged.
- R6: irq is high exactly when (frame-done and mask bit 3) or (palette-done and mask bit 4) or sync-fault holds. Sync-fault is not masked.
- R7: A control write that turns the on-bit from 1 to 0 clears sync-fault. It also sets frame-done unless the written palette mode is 1; with mode 1, frame-done keeps its value.
- R8: A control write that turns the on-bit from 0 to 1 clears frame-done and palette-done. A control write that leaves the on-bit unchanged does not touch the flags.
- R9: Pulses on evt_frame_done, evt_palette_done and evt_sync_err set their flag at the next clock. A clear caused by an on/off transition in the same cycle wins over the pulse.
- R10: Reset clears every stored field and flag. A read of 0x00 then gives 0xFE000C34, of 0x04 gives 0x3FF, of 0x08 gives 0x3FF, of 0x0C gives 0xFC000000, and of 0x10 gives 0. Other offsets read 0 and ignore writes. bus_rdata is 0 unless a read access is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| evt_frame_done | input | 1 | Pulse: frame finished |
| evt_palette_done | input | 1 | Pulse: palette loaded |
| evt_sync_err | input | 1 | Pulse: synchronisation fault |
| panel_en | output | 1 | Stored on-bit |
| panel_width | output | 11 | Decoded width in pixels |
| panel_height | output | 11 | Decoded height in lines |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a sequencer event that arrives in the same cycle as an on/off transition. There the flag logic must settle the conflict between a set and a clear. The bench drives the control write and the event pulse on the same falling edge, once while turning the panel on and once while turning it off. It then reads status to check which side won. It also walks the flags through each interrupt mask setting, so the unmasked sync-fault path is told apart from the masked paths.

// File: rtl/panel_ctl_pkg.sv
package panel_ctl_pkg;
  localparam int DATA_W   = 32;
  localparam int DIM_W    = 10;
  localparam int SIZE_W   = DIM_W + 1;
  localparam int HI_W     = DATA_W - DIM_W;
  localparam int NREG     = 6;

  // register index = byte offset / 4
  localparam int IDX_CTL  = 0;
  localparam int IDX_TM0  = 1;
  localparam int IDX_TM1  = 2;
  localparam int IDX_TM2  = 3;
  localparam int IDX_STAT = 4;
  localparam int IDX_SUB  = 5;

  localparam logic [31:0] CTL_KEEP  = 32'h01CF_F300;
  localparam logic [31:0] CTL_ONES  = 32'hFE00_0C34;
  localparam logic [31:0] TM0_ONES  = 32'h0000_000F;
  localparam logic [31:0] TM2_ONES  = 32'hFC00_0000;
  localparam logic [31:0] SUB_KEEP  = 32'hA1FF_FFFF;

  typedef struct packed {
    logic        on;
    logic        mono;
    logic [1:0]  imask;
    logic        tft;
    logic [1:0]  pmode;
    logic [31:0] extra;
  } ctl_t;

  function automatic ctl_t ctl_from_word(input logic [31:0] w);
    ctl_t c;
    c.on    = w[0];
    c.mono  = w[1];
    c.imask = w[4:3];
    c.tft   = w[7];
    c.pmode = w[21:20];
    c.extra = w & CTL_KEEP;
    return c;
  endfunction

  function automatic logic [31:0] ctl_image(input ctl_t c);
    logic [31:0] w;
    w = CTL_ONES | c.extra;
    w[0]     = w[0] | c.on;
    w[1]     = w[1] | c.mono;
    w[4:3]   = w[4:3] | c.imask;
    w[7]     = w[7] | c.tft;
    w[21:20] = w[21:20] | c.pmode;
    w[23]    = w[23] | c.tft;
    return w;
  endfunction

  function automatic logic [31:0] dim_image(input logic [HI_W-1:0] hi,
                                            input logic [SIZE_W-1:0] size,
                                            input logic [31:0] ones);
    logic [SIZE_W-1:0] m1;
    m1 = size - SIZE_W'(1);
    return {hi, m1[DIM_W-1:0]} | ones;
  endfunction

  function automatic logic [31:0] stat_image(input logic fd, input logic pd,
                                             input logic se);
    logic [31:0] w;
    w    = '0;
    w[0] = fd;
    w[2] = se;
    w[6] = pd;
    return w;
  endfunction
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 6
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit,
  output logic [NREG-1:0]   wr_stb,
  output logic              rd_en
);
  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_hit
      assign hit[gi]    = (addr == ADDR_W'(gi * 4));
      assign wr_stb[gi] = sel && wr && hit[gi];
    end
  endgenerate
  assign rd_en = sel && !wr;
endmodule

// File: rtl/pcr_flags.sv
module pcr_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       on_q,
  input  logic       on_new,
  input  logic [1:0] pmode_new,
  input  logic       evt_fd,
  input  logic       evt_pd,
  input  logic       evt_se,
  output logic       go_on,
  output logic       go_off,
  output logic       fd_q,
  output logic       pd_q,
  output logic       se_q
);
  assign go_on  = ctl_wr && !on_q && on_new;
  assign go_off = ctl_wr && on_q && !on_new;

  logic fd_d, pd_d, se_d;
  always_comb begin
    fd_d = fd_q | evt_fd;
    pd_d = pd_q | evt_pd;
    se_d = se_q | evt_se;
    if (go_on) begin
      fd_d = 1'b0;
      pd_d = 1'b0;
    end
    if (go_off) begin
      se_d = 1'b0;
      if (pmode_new != 2'd1) fd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd_q <= 1'b0;
      pd_q <= 1'b0;
      se_q <= 1'b0;
    end else begin
      fd_q <= fd_d;
      pd_q <= pd_d;
      se_q <= se_d;
    end
  end
endmodule

// File: rtl/pcr_irq.sv
module pcr_irq (
  input  logic       fd,
  input  logic       pd,
  input  logic       se,
  input  logic [1:0] imask,
  output logic       irq
);
  assign irq = (fd && imask[0]) || (pd && imask[1]) || se;
endmodule

// File: rtl/panel_ctl_regs.sv
module panel_ctl_regs
  import panel_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_frame_done,
  input  logic              evt_palette_done,
  input  logic              evt_sync_err,
  output logic              panel_en,
  output logic [10:0]       panel_width,
  output logic [10:0]       panel_height,
  output logic              irq
);
  logic [NREG-1:0] hit, wr_stb;
  logic            rd_en;

  pcr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .hit(hit), .wr_stb(wr_stb), .rd_en(rd_en)
  );

  ctl_t              ctl_q;
  ctl_t              ctl_new;
  logic [HI_W-1:0]   tm0_hi, tm1_hi;
  logic [SIZE_W-1:0] width_q, height_q;
  logic [31:0]       tm2_q, sub_q;

  assign ctl_new = ctl_from_word(bus_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      tm0_hi   <= '0;
      tm1_hi   <= '0;
      width_q  <= '0;
      height_q <= '0;
      tm2_q    <= '0;
      sub_q    <= '0;
    end else begin
      if (wr_stb[IDX_CTL]) ctl_q <= ctl_new;
      if (wr_stb[IDX_TM0]) begin
        tm0_hi  <= bus_wdata[31:DIM_W];
        width_q <= SIZE_W'(bus_wdata[DIM_W-1:0]) + SIZE_W'(1);
      end
      if (wr_stb[IDX_TM1]) begin
        tm1_hi   <= bus_wdata[31:DIM_W];
        height_q <= SIZE_W'(bus_wdata[DIM_W-1:0]) + SIZE_W'(1);
      end
      if (wr_stb[IDX_TM2]) tm2_q <= bus_wdata;
      if (wr_stb[IDX_SUB]) sub_q <= bus_wdata & SUB_KEEP;
    end
  end

  logic go_on, go_off, fd_q, pd_q, se_q;

  pcr_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(wr_stb[IDX_CTL]), .on_q(ctl_q.on),
    .on_new(ctl_new.on), .pmode_new(ctl_new.pmode),
    .evt_fd(evt_frame_done), .evt_pd(evt_palette_done),
    .evt_se(evt_sync_err),
    .go_on(go_on), .go_off(go_off),
    .fd_q(fd_q), .pd_q(pd_q), .se_q(se_q)
  );

  pcr_irq u_irq (
    .fd(fd_q), .pd(pd_q), .se(se_q), .imask(ctl_q.imask), .irq(irq)
  );

  logic [31:0] img [NREG];
  assign img[IDX_CTL]  = ctl_image(ctl_q);
  assign img[IDX_TM0]  = dim_image(tm0_hi, width_q, TM0_ONES);
  assign img[IDX_TM1]  = dim_image(tm1_hi, height_q, '0);
  assign img[IDX_TM2]  = tm2_q | TM2_ONES;
  assign img[IDX_STAT] = stat_image(fd_q, pd_q, se_q);
  assign img[IDX_SUB]  = sub_q;

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_en && hit[i]) bus_rdata = img[i];
  end

  assign panel_en     = ctl_q.on;
  assign panel_width  = width_q;
  assign panel_height = height_q;
endmodule

// File: rtl/pcr_checker.sv
module pcr_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              evt_fd,
  input logic              evt_pd,
  input logic              evt_se,
  input logic              go_on,
  input logic              go_off,
  input logic              fd_q,
  input logic              pd_q,
  input logic              se_q,
  input logic              irq
);
  logic undef_addr;
  assign undef_addr = (bus_addr > ADDR_W'(8'h14)) || (bus_addr[1:0] != 2'b00);

  a_r6_fault_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    se_q |-> irq);
  a_r6_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!fd_q && !pd_q && !se_q) |-> !irq);
  a_r7_off_clears_fault: assert property (@(posedge clk) disable iff (!rst_n)
    go_off |=> !se_q);
  a_r7_off_sets_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (go_off && bus_wdata[21:20] != 2'd1) |=> fd_q);
  a_r8_on_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    go_on |=> (!fd_q && !pd_q));
  a_r9_frame_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fd && !go_on) |=> fd_q);
  a_r4_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(8'h10) && !evt_fd && !evt_pd && !evt_se)
      |=> $stable({fd_q, pd_q, se_q}));
  a_r10_undef_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && undef_addr) |-> bus_rdata == 32'h0);
endmodule

bind panel_ctl_regs pcr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .evt_fd(evt_frame_done), .evt_pd(evt_palette_done), .evt_se(evt_sync_err),
  .go_on(go_on), .go_off(go_off), .fd_q(fd_q), .pd_q(pd_q), .se_q(se_q),
  .irq(irq)
);

// File: tb/tb_panel_ctl_regs.sv
module tb_panel_ctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_f = 1'b0, evt_p = 1'b0, evt_s = 1'b0;
  logic        panel_en, irq;
  logic [10:0] panel_width, panel_height;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_ctl_regs #(.ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_frame_done(evt_f), .evt_palette_done(evt_p), .evt_sync_err(evt_s),
    .panel_en(panel_en), .panel_width(panel_width),
    .panel_height(panel_height), .irq(irq)
  );

  // {offset, write data, expected readback}
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h00, 32'hFFFF_FFFE, 32'hFFFF_FFBE}, // R1 all fields, on-bit 0
    {8'h00, 32'h0000_0082, 32'hFE80_0CB6}, // R1 tft echo in bit 23
    {8'h00, 32'h0010_0000, 32'hFE10_0C34}, // R1 palette mode
    {8'h04, 32'h0000_0013, 32'h0000_001F}, // R2 low nibble forced
    {8'h04, 32'hABCD_E7FF, 32'hABCD_E7FF}, // R2 full field
    {8'h04, 32'h0000_0000, 32'h0000_000F}, // R2 width 1
    {8'h08, 32'h1234_5005, 32'h1234_5005}, // R3 height word
    {8'h0C, 32'h0000_1234, 32'hFC00_1234}, // R3 forced top bits
    {8'h0C, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R3
    {8'h14, 32'hFFFF_FFFF, 32'hA1FF_FFFF}, // R5 mask
    {8'h14, 32'h5E00_0001, 32'h0000_0001}, // R5 masked-out bits
    {8'h10, 32'hFFFF_FFFF, 32'h0000_0000}, // R4 status write ignored
    {8'h18, 32'hFFFF_FFFF, 32'h0000_0000}, // R10 undefined offset
    {8'hFC, 32'h0000_0001, 32'h0000_0000}  // R10 undefined offset
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d,
                           input logic f, input logic p, input logic s);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    evt_f = f; evt_p = p; evt_s = s;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    evt_f = 1'b0; evt_p = 1'b0; evt_s = 1'b0;
  endtask

  task automatic pulse(input logic f, input logic p, input logic s);
    @(negedge clk);
    evt_f = f; evt_p = p; evt_s = s;
    @(negedge clk);
    evt_f = 1'b0; evt_p = 1'b0; evt_s = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    bus_read(8'h00, rd); check("R10 ctl after reset", rd, 32'hFE00_0C34);
    bus_read(8'h04, rd); check("R10 tm0 after reset", rd, 32'h0000_03FF);
    bus_read(8'h08, rd); check("R10 tm1 after reset", rd, 32'h0000_03FF);
    bus_read(8'h0C, rd); check("R10 tm2 after reset", rd, 32'hFC00_0000);
    bus_read(8'h10, rd); check("R10 status after reset", rd, 32'h0);
    check("R10 irq after reset", {31'd0, irq}, 32'd0);
    check("R10 width after reset", {21'd0, panel_width}, 32'd0);
    #1 check("R10 rdata idle", bus_rdata, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][71:64], VEC[i][63:32], 1'b0, 1'b0, 1'b0);
      bus_read(VEC[i][71:64], rd);
      check($sformatf("vector %0d (R1..R5,R10 table)", i), rd, VEC[i][31:0]);
    end

    // R2 / R3 decoded sizes
    bus_write(8'h04, 32'h0000_0013, 1'b0, 1'b0, 1'b0);
    bus_write(8'h08, 32'h0000_0005, 1'b0, 1'b0, 1'b0);
    check("R2 panel_width", {21'd0, panel_width}, 32'd20);
    check("R3 panel_height", {21'd0, panel_height}, 32'd6);

    // R8 + R9 + R6: turn on with both masks, frame pulse
    bus_write(8'h00, 32'h0000_0019, 1'b0, 1'b0, 1'b0);
    check("R8 panel_en", {31'd0, panel_en}, 32'd1);
    pulse(1'b1, 1'b0, 1'b0);
    bus_read(8'h10, rd); check("R9 frame flag", rd, 32'h1);
    check("R6 irq frame masked in", {31'd0, irq}, 32'd1);
    bus_write(8'h00, 32'h0000_0011, 1'b0, 1'b0, 1'b0);
    check("R6 irq frame masked out", {31'd0, irq}, 32'd0);
    pulse(1'b0, 1'b1, 1'b0);
    bus_read(8'h10, rd); check("R9 palette flag", rd, 32'h41);
    check("R6 irq palette", {31'd0, irq}, 32'd1);
    bus_write(8'h00, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
    check("R6 irq all masked", {31'd0, irq}, 32'd0);
    pulse(1'b0, 1'b0, 1'b1);
    bus_read(8'h10, rd); check("R9 fault flag", rd, 32'h45);
    check("R6 fault unmasked", {31'd0, irq}, 32'd1);

    // R4 status write ignored
    bus_write(8'h10, 32'h0, 1'b0, 1'b0, 1'b0);
    bus_read(8'h10, rd); check("R4 status write ignored", rd, 32'h45);

    // R7 turn off, mode 0
    bus_write(8'h00, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    bus_read(8'h10, rd); check("R7 off mode0", rd, 32'h41);
    check("R7 irq after off", {31'd0, irq}, 32'd0);

    // R8 turn on clears
    bus_write(8'h00, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
    bus_read(8'h10, rd); check("R8 on clears", rd, 32'h0);

    // R7 turn off with palette mode 1
    pulse(1'b0, 1'b0, 1'b1);
    check("R6 fault irq", {31'd0, irq}, 32'd1);
    bus_write(8'h00, 32'h0010_0000, 1'b0, 1'b0, 1'b0);
    bus_read(8'h10, rd); check("R7 off mode1", rd, 32'h0);

    // R9 same-cycle conflicts
    bus_write(8'h00, 32'h0000_0001, 1'b1, 1'b0, 1'b0);
    bus_read(8'h10, rd); check("R9 on beats frame pulse", rd, 32'h0);
    bus_write(8'h00, 32'h0000_0000, 1'b0, 1'b0, 1'b1);
    bus_read(8'h10, rd); check("R9 off beats fault pulse", rd, 32'h1);

    // R8 no transition, no flag change
    bus_write(8'h00, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    bus_write(8'h00, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
    bus_read(8'h10, rd); check("R8 rewrite keeps flags", rd, 32'h40);

    summary();
    $finish;
  end
endmodule